// File: doc/BRIEF.md
# Prescaled System Counter Unit

This block is a memory-mapped timer unit that runs from one core clock and keeps four counters. A down-counting prescale counter reloads from a programmable reload value. A 32-bit event counter advances each time the prescale counter reloads. Two free-running 32-bit rate counters advance at roughly 100 Hz and 1 Hz. Each time base comes from its own divider on the core clock, and every divide ratio is a parameter.

Software reaches the unit through a simple word-addressed register port. The port has single-cycle read and write strobes and 32-bit data. All five registers can be read. The reload value, the event counter and both rate counters can be written. A write to a rate counter or to the event counter replaces its value, and counting carries on from the new value. A write to the reload value only changes the next reload. The prescale counter itself is read-only.

The prescale counter stays at zero for one full tick before it reloads. The event counter advances on that reload tick. With a reload value of zero the prescale counter stays at zero, and the event counter advances on every prescale tick.

Top module: `sysctr_unit`

## Requirements
- R1: After reset, the reload value, the prescale counter, the event counter and both rate counters all read zero, and `err_o` is low.
- R2: The prescale tick fires once every `PS_DIV` core cycles. On each tick with the prescale counter nonzero, the counter drops by one.
- R3: On a prescale tick with the prescale counter at zero, the counter loads the reload value and the event counter rises by one on that same tick. The event counter wraps from 0xFFFFFFFF to 0.
- R4: With a reload value of zero, the prescale counter stays at zero and the event counter rises by one on every prescale tick.
- R5: A write of the reload value leaves the prescale counter as it is and is used only at the next reload. A prescale counter above the reload value counts down to zero before it reloads.
- R6: A write of the event counter loads the written value. If an increment falls on the same cycle, the write wins and the increment is lost.
- R7: The rate counters at word addresses 3 and 4 rise by one every `HZ100_DIV` and `HZ1_DIV` core cycles respectively, and wrap at 32 bits. A write loads the value, and counting continues from it.
- R8: The register map uses word addresses: 0 is the reload value (read/write), 1 is the prescale counter (read-only), 2 is the event counter, 3 is the 100 Hz counter and 4 is the 1 Hz counter. Read data appears on `rdata_o` one cycle after `rd_i` and holds until the next read.
- R9: A read of an address of 5 or above returns zero. Any access to such an address drives `err_o` high for the cycle after the strobe. A write to an unmapped address or to address 1 changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| err_o | output | 1 | Unmapped-address flag, one cycle |

## Verification
A read strobe captured at core edge e returns the state left by edge e-1. Because `rdata_o` and `err_o` are registered, both appear one cycle later, and the bench samples them on the following falling edge. A write captured at edge e takes effect at that edge. The bench counts core edges since reset and derives the number of divider ticks in any span from that count. It keeps an epoch for each counter, made of the edge and the state at the last write. From the epoch it gets every expected value in closed form. The write sequences use gaps of varied length, so that some writes land on the same edge as a tick.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    SEL_RELOAD = 3'd0,
    SEL_PSCNT  = 3'd1,
    SEL_COUNT  = 3'd2,
    SEL_HZ100  = 3'd3,
    SEL_HZ1    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/sysctr_tick_div.sv
module sysctr_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sysctr_presc.sv
module sysctr_presc
  import sysctr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  reload_we_i,
  input  logic  count_we_i,
  input  word_t wdata_i,
  output word_t reload_o,
  output word_t pscnt_o,
  output word_t count_o
);
  word_t reload_q, pscnt_q, count_q;
  logic  at_zero;

  assign at_zero = (pscnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      pscnt_q  <= '0;
      count_q  <= '0;
    end else begin
      if (reload_we_i) reload_q <= wdata_i;
      // reload uses the value held before any same-cycle write
      if (tick_i) pscnt_q <= at_zero ? reload_q : pscnt_q - 1'b1;
      if (count_we_i)             count_q <= wdata_i;
      else if (tick_i && at_zero) count_q <= count_q + 1'b1;
    end
  end

  assign reload_o = reload_q;
  assign pscnt_o  = pscnt_q;
  assign count_o  = count_q;
endmodule

// File: rtl/sysctr_rate.sv
module sysctr_rate
  import sysctr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  we_i,
  input  word_t wdata_i,
  output word_t value_o
);
  word_t val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (we_i)   val_q <= wdata_i;
    else if (tick_i) val_q <= val_q + 1'b1;
  end

  assign value_o = val_q;
endmodule

// File: rtl/sysctr_unit.sv
module sysctr_unit
  import sysctr_pkg::*;
#(
  parameter int unsigned PS_DIV    = 5,
  parameter int unsigned HZ100_DIV = 1_000_000,
  parameter int unsigned HZ1_DIV   = 100_000_000,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  localparam int unsigned NRATE = 2;
  localparam int unsigned RATE_DIV [NRATE] = '{HZ100_DIV, HZ1_DIV};
  localparam logic [ADDR_W-1:0] RATE_ADDR [NRATE] =
    '{ADDR_W'(SEL_HZ100), ADDR_W'(SEL_HZ1)};

  logic  ps_tick;
  logic  mapped, reload_we, count_we;
  word_t reload, pscnt, count, rd_mux;
  word_t rate_val [NRATE];

  assign mapped    = (addr_i < ADDR_W'(NUM_REGS));
  assign reload_we = wr_i && (addr_i == ADDR_W'(SEL_RELOAD));
  assign count_we  = wr_i && (addr_i == ADDR_W'(SEL_COUNT));

  sysctr_tick_div #(.DIV(PS_DIV)) u_ps_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(ps_tick)
  );

  sysctr_presc u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ps_tick),
    .reload_we_i(reload_we),
    .count_we_i (count_we),
    .wdata_i    (wdata_i),
    .reload_o   (reload),
    .pscnt_o    (pscnt),
    .count_o    (count)
  );

  for (genvar i = 0; i < NRATE; i++) begin : g_rate
    logic tick;
    sysctr_tick_div #(.DIV(RATE_DIV[i])) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_o(tick)
    );
    sysctr_rate u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .we_i   (wr_i && (addr_i == RATE_ADDR[i])),
      .wdata_i(wdata_i),
      .value_o(rate_val[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      case (addr_i[2:0])
        SEL_RELOAD: rd_mux = reload;
        SEL_PSCNT:  rd_mux = pscnt;
        SEL_COUNT:  rd_mux = count;
        SEL_HZ100:  rd_mux = rate_val[0];
        SEL_HZ1:    rd_mux = rate_val[1];
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_i) rdata_o <= rd_mux;
      err_o <= (rd_i || wr_i) && !mapped;
    end
  end
endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic              ps_tick,
  input logic              count_we,
  input logic [31:0]       reload,
  input logic [31:0]       pscnt,
  input logic [31:0]       count
);
  // R2
  a_r2_pscnt_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_tick && pscnt != 0 |=> pscnt == $past(pscnt) - 1);
  // R3
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_tick && pscnt == 0 |=> pscnt == $past(reload));
  // R3
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_tick && pscnt == 0 && !count_we |=> count == $past(count) + 1);
  // R2
  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ps_tick |=> $stable(pscnt));
  // R6
  a_r6_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ps_tick && !count_we |=> $stable(count));
  // R9
  a_r9_err_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> !err_o);
  // R9
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i >= ADDR_W'(5) |=> rdata_o == 0 && err_o);
endmodule

bind sysctr_unit sysctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .ps_tick (ps_tick),
  .count_we(count_we),
  .reload  (reload),
  .pscnt   (pscnt),
  .count   (count)
);

// File: tb/sim_sysctr_unit.sv
module sim_sysctr_unit;
  localparam int D_PS = 3, D_100 = 5, D_1 = 11, AW = 4;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err;
  int n_run = 0, n_fail = 0;
  longint n = 0;

  longint p_e0 = 0, p_s0 = 0, p_c0 = 0, p_rl = 0;
  longint r_e0 [2] = '{0, 0};
  longint r_v0 [2] = '{0, 0};

  always #2 clk = ~clk;

  sysctr_unit #(.PS_DIV(D_PS), .HZ100_DIV(D_100), .HZ1_DIV(D_1), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) n <= 0; else n <= n + 1;

  function automatic longint ticks(longint a, longint b, longint d);
    return b / d - a / d;
  endfunction

  // state after edge e from the prescaler epoch
  task automatic model_at(input longint e, output longint s, output longint c);
    longint t, y;
    t = ticks(p_e0, e, D_PS);
    if (t < p_s0) begin s = p_s0 - t; c = p_c0; end
    else begin
      y = t - p_s0 + p_rl;
      s = p_rl - (y % (p_rl + 1));
      c = (p_c0 + y / (p_rl + 1)) & MASK;
    end
  endtask

  function automatic longint rate_at(int i, longint e);
    return (r_v0[i] + ticks(r_e0[i], e, (i == 0) ? D_100 : D_1)) & MASK;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd_op(int a, output logic [31:0] d, output logic er, output longint e);
    @(negedge clk); rd = 1'b1; addr = AW'(a);
    @(posedge clk); #1 e = n;
    @(negedge clk); rd = 1'b0; d = rdata; er = err;
  endtask

  task automatic wr_op(int a, longint v, output logic er);
    longint e, s, c;
    @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = v[31:0];
    @(posedge clk); #1 e = n;
    case (a)
      0: begin model_at(e, s, c); p_e0 = e; p_s0 = s; p_c0 = c; p_rl = v & MASK; end
      2: begin model_at(e, s, c); p_e0 = e; p_s0 = s; p_c0 = v & MASK; end
      3: begin r_e0[0] = e; r_v0[0] = v & MASK; end
      4: begin r_e0[1] = e; r_v0[1] = v & MASK; end
      default: ;
    endcase
    @(negedge clk); wr = 1'b0; er = err;
  endtask

  task automatic check_reg(int a, string tag);
    logic [31:0] d; logic er; longint e, s, c, x;
    rd_op(a, d, er, e);
    model_at(e - 1, s, c);
    case (a)
      0: x = p_rl;
      1: x = s;
      2: x = c;
      3: x = rate_at(0, e - 1);
      4: x = rate_at(1, e - 1);
      default: x = 0;
    endcase
    chk(tag, d, x);
    chk({tag, " err"}, er, 0);
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    logic er; logic [31:0] d; longint e;
    int pv [4] = '{5, 0, 1, 3};
    #9 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) check_reg(a, "R1");
    // R2 R3 R4 sweep over reload values
    foreach (pv[i]) begin
      wr_op(0, pv[i], er);
      for (int k = 0; k < 20; k++) begin
        check_reg(1, (pv[i] == 0) ? "R4" : "R2");
        check_reg(2, (pv[i] == 0) ? "R4" : "R3");
        idle(k % 3);
      end
    end
    // R5 start above reload, reload change deferred
    wr_op(0, 7, er); idle(40);
    wr_op(0, 5, er);
    check_reg(0, "R8");
    for (int k = 0; k < 20; k++) begin check_reg(1, "R5"); idle(k % 2); end
    // R6 load event counter at all divider phases, R3 wrap
    for (int j = 0; j < 8; j++) begin
      wr_op(2, 64'hFFFF_FFF0 + j, er);
      idle(j % 3);
      check_reg(2, "R6");
      check_reg(1, "R6");
    end
    wr_op(0, 0, er); wr_op(2, 64'hFFFF_FFFE, er);
    for (int k = 0; k < 6; k++) check_reg(2, "R3");
    // R7 rate counters
    wr_op(3, 123, er);
    wr_op(4, 64'hFFFF_FFFF, er);
    for (int k = 0; k < 15; k++) begin
      check_reg(3, "R7"); check_reg(4, "R7"); idle(k % 4);
    end
    // R9 unmapped accesses and read-only counter
    wr_op(0, 4, er);
    rd_op(7, d, er, e);  chk("R9 data", d, 0); chk("R9 err", er, 1);
    @(negedge clk); chk("R9 err clear", err, 0);
    rd_op(15, d, er, e); chk("R9 data", d, 0); chk("R9 err", er, 1);
    wr_op(9, 32'h55, er); chk("R9 wr err", er, 1);
    wr_op(1, 32'h1234, er); chk("R9 ro err", er, 0);
    for (int k = 0; k < 5; k++) begin
      check_reg(1, "R9"); check_reg(2, "R9"); check_reg(3, "R9");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule